// File: doc/BRIEF.md
# Power Mode Controller for an 8-bit Microcontroller

This block sits beside an 8-bit microcontroller core and turns writes to its power control register into clock enables. Every clock edge of `clk` is one oscillator period. A free-running prescaler marks machine-cycle boundaries, one every twelve oscillator periods. Two software modes are managed.

In slow-down mode every oscillator-derived enable runs at one eighth of its normal rate. This covers the CPU, the peripherals, the watchdog and the machine-cycle strobe that drives the clock-out. Slow-down switches on and off only at a machine-cycle boundary.

Idle mode stops the CPU and watchdog enables while the peripheral enable keeps running. Idle needs a guarded pair of writes on consecutive instructions. It ends on an enabled interrupt request or on a hardware reset. While idle, the bus strobe hold outputs and the port freeze output are high.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset, `sfr_rdata` reads 0x00, `idle_active` and `slow_active` are low, the CPU, peripheral and watchdog enables are high, and the three hold outputs are low.
- R2: With slow-down off, `per_clk_en` is high every oscillator period and `mc_stb` pulses once every 12 periods. With slow-down on, `per_clk_en`, `cpu_clk_en` and `wdt_clk_en` pulse once every 8 periods and `mc_stb` once every 96 periods.
- R3: A write to address 0x87 with bit 4 (SD) set shows SD in `sfr_rdata` on the next clock. `slow_active` follows SD only at a machine-cycle boundary: it rises within 12 periods of the write and falls within 96 periods of the write that clears SD.
- R4: Idle starts when a write to 0x87 with bit 0 set is followed, at the very next retire event, by a write to 0x87 with bit 5 set. `idle_active` is high on the clock after the second write. An SFR write counts as the retire of its own instruction.
- R5: A single write with both bits set does not start idle. A write with bit 5 set and no armed bit 0 does not start idle. Two writes separated by an `instr_retire` that carries no register write do not start idle, and that retire clears bit 0 in `sfr_rdata`.
- R6: During idle, `cpu_clk_en` and `wdt_clk_en` are low and `per_clk_en` keeps its pattern. `addr_latch_hold`, `prog_strobe_hold` and `port_freeze` are high, and `sfr_rdata` bits 5 and 0 read 1.
- R7: `irq_pending` high while idle ends idle on the next clock. After that, `cpu_clk_en` is back, and `sfr_rdata` bits 5 and 0 read 0.
- R8: Asserting `rst_n` low during idle ends idle, and after release the block is in the R1 state.
- R9: While `sw_save_en` is low, writes leave SD, bit 0 and bit 5 unchanged and cannot start idle. Bits 7, 6, 3, 2 and 1 are still stored.
- R10: Bits 7, 6, 3, 2 and 1 read back as last written. Writes to any address other than 0x87 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| sfr_we | input | 1 | Special-function register write strobe |
| sfr_addr | input | 8 | Special-function register address |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Power control register read value |
| instr_retire | input | 1 | Pulse when an instruction completes |
| irq_pending | input | 1 | An enabled interrupt is requesting service |
| sw_save_en | input | 1 | Allows the software power-saving modes |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| mc_stb | output | 1 | Machine-cycle boundary strobe (clock-out source) |
| slow_active | output | 1 | Slow-down divider engaged |
| idle_active | output | 1 | Idle mode in force |
| addr_latch_hold | output | 1 | Forces the address latch strobe high |
| prog_strobe_hold | output | 1 | Forces the program fetch strobe high |
| port_freeze | output | 1 | Port latches hold their entry values |

## Verification
The assertions assume the core is halted while idle, so no SFR write or retire pulse arrives then. They also assume `irq_pending` is never raised in the same cycle as the write that enters idle. The random stimulus drives writes and retires only while the bench model says the block is running, and raises interrupts only while it says the block is idle. Directed sequences cover the boundary timing of slow-down, the broken and single-write idle attempts, reset during idle and the locked-out writes.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int OSC_PER_MC = 12,
  parameter int SLOW_DIV = 8,
  parameter logic [7:0] PCON_ADDR = 8'h87
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sfr_we,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  input  logic       instr_retire,
  input  logic       irq_pending,
  input  logic       sw_save_en,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       wdt_clk_en,
  output logic       mc_stb,
  output logic       slow_active,
  output logic       idle_active,
  output logic       addr_latch_hold,
  output logic       prog_strobe_hold,
  output logic       port_freeze
);
  localparam int MCW = $clog2(OSC_PER_MC);
  localparam int DVW = $clog2(SLOW_DIV);
  localparam int IDLE_BIT = 0;
  localparam int SD_BIT = 4;
  localparam int IDLS_BIT = 5;

  logic           sd_q, arm_q, idle_q, slow_q;
  logic [1:0]     hi_q;
  logic [2:0]     lo_q;
  logic [DVW-1:0] dv_q;
  logic [MCW-1:0] mc_q;

  logic wr, retire, sw_set, base_en, idle_go, arm_d, idle_d;

  assign wr      = sfr_we && (sfr_addr == PCON_ADDR);
  assign retire  = instr_retire || wr;
  assign sw_set  = wr && sw_save_en;
  assign base_en = !slow_q || (dv_q == DVW'(SLOW_DIV - 1));
  assign mc_stb  = base_en && (mc_q == MCW'(OSC_PER_MC - 1));
  assign idle_go = sw_set && arm_q && sfr_wdata[IDLS_BIT];

  always_comb begin
    arm_d = arm_q;
    if (retire)
      arm_d = sw_set && sfr_wdata[IDLE_BIT] && !idle_go;
    if (idle_q && irq_pending)
      arm_d = 1'b0;
  end

  assign idle_d = idle_q ? !irq_pending : idle_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q <= '0;
      mc_q <= '0;
    end else begin
      if (!slow_q || dv_q == DVW'(SLOW_DIV - 1))
        dv_q <= '0;
      else
        dv_q <= dv_q + 1'b1;
      if (base_en)
        mc_q <= (mc_q == MCW'(OSC_PER_MC - 1)) ? '0 : mc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_q   <= 1'b0;
      slow_q <= 1'b0;
      arm_q  <= 1'b0;
      idle_q <= 1'b0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      if (sw_set)
        sd_q <= sfr_wdata[SD_BIT];
      if (mc_stb)
        slow_q <= sd_q;
      if (wr) begin
        hi_q <= sfr_wdata[7:6];
        lo_q <= sfr_wdata[3:1];
      end
      arm_q  <= arm_d;
      idle_q <= idle_d;
    end
  end

  assign sfr_rdata        = {hi_q, idle_q, sd_q, lo_q, arm_q | idle_q};
  assign per_clk_en       = base_en;
  assign cpu_clk_en       = base_en && !idle_q;
  assign wdt_clk_en       = base_en && !idle_q;
  assign slow_active      = slow_q;
  assign idle_active      = idle_q;
  assign addr_latch_hold  = idle_q;
  assign prog_strobe_hold = idle_q;
  assign port_freeze      = idle_q;

  AST_SLOW_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_q != $past(slow_q)) |-> $past(mc_stb)); // R3
  AST_SLOW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_q && per_clk_en && mc_q != '0) |=> (!per_clk_en || !slow_q)); // R2
  AST_IDLE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_q) |-> $past(arm_q)); // R4
  AST_IRQ_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q && irq_pending) |=> (!idle_q && !arm_q)); // R7
  AST_SW_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !sw_save_en) |=> (sd_q == $past(sd_q) && !$rose(idle_q))); // R9
endmodule

// File: tb/test_pwr_mode_ctl.sv
module test_pwr_mode_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sfr_we = 1'b0, instr_retire = 1'b0, irq_pending = 1'b0, sw_save_en = 1'b1;
  logic [7:0] sfr_addr = 8'h00, sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic cpu_clk_en, per_clk_en, wdt_clk_en, mc_stb, slow_active, idle_active;
  logic addr_latch_hold, prog_strobe_hold, port_freeze;

  int vecs = 0, errs = 0;
  logic m_sd, m_arm, m_idle;
  logic [7:0] m_keep;

  pwr_mode_ctl i_pwr_mode_ctl (
    .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .instr_retire(instr_retire),
    .irq_pending(irq_pending), .sw_save_en(sw_save_en), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .wdt_clk_en(wdt_clk_en), .mc_stb(mc_stb),
    .slow_active(slow_active), .idle_active(idle_active),
    .addr_latch_hold(addr_latch_hold), .prog_strobe_hold(prog_strobe_hold),
    .port_freeze(port_freeze));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d,
                      input logic ret, input logic irq);
    sfr_we = we; sfr_addr = a; sfr_wdata = d; instr_retire = ret; irq_pending = irq;
    @(negedge clk);
    sfr_we = 1'b0; instr_retire = 1'b0; irq_pending = 1'b0;
  endtask

  task automatic wpcon(input logic [7:0] d);
    step(1'b1, 8'h87, d, 1'b1, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (24) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic measure(input int n, output int per, output int mc, output int cpu, output int wdt);
    per = 0; mc = 0; cpu = 0; wdt = 0;
    for (int i = 0; i < n; i++) begin
      per += int'(per_clk_en); mc += int'(mc_stb);
      cpu += int'(cpu_clk_en); wdt += int'(wdt_clk_en);
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] read_model();
    return {m_keep[7:6], m_idle, m_sd, m_keep[3:1], m_arm | m_idle};
  endfunction

  task automatic model_step(input logic we, input logic [7:0] a, input logic [7:0] d,
                            input logic ret, input logic irq, input logic en);
    logic hit;
    hit = we && a == 8'h87;
    if (m_idle) begin
      if (irq) begin m_idle = 1'b0; m_arm = 1'b0; end
    end else if (hit) begin
      m_keep = d & 8'hCE;
      if (en) begin
        m_sd = d[4];
        if (m_arm && d[5]) begin m_idle = 1'b1; m_arm = 1'b0; end
        else m_arm = d[0];
      end else m_arm = 1'b0;
    end else if (ret) m_arm = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int per, mc, cpu, wdt, k;
    process::self().srandom(32'd1234);
    do_reset();
    chk("R1 rdata", sfr_rdata, 8'h00);
    chk("R1 idle/slow", {idle_active, slow_active}, 0);
    chk("R1 enables", {cpu_clk_en, per_clk_en, wdt_clk_en}, 3'b111);
    chk("R1 holds", {addr_latch_hold, prog_strobe_hold, port_freeze}, 0);

    measure(120, per, mc, cpu, wdt);
    chk("R2 normal per", per, 120);
    chk("R2 normal mc", mc, 10);

    wpcon(8'h10);
    chk("R3 SD readback", sfr_rdata, 8'h10);
    k = 0;
    while (!slow_active && k < 20) begin @(negedge clk); k++; end
    chk("R3 slow within 12", int'(k <= 12 && slow_active), 1);
    measure(192, per, mc, cpu, wdt);
    chk("R2 slow per", per, 24);
    chk("R2 slow mc", mc, 2);
    chk("R2 slow cpu", cpu, 24);
    chk("R2 slow wdt", wdt, 24);
    wpcon(8'h00);
    k = 0;
    while (slow_active && k < 120) begin @(negedge clk); k++; end
    chk("R3 slow off within 96", int'(k <= 96 && !slow_active), 1);
    measure(120, per, mc, cpu, wdt);
    chk("R3 normal again mc", mc, 10);

    wpcon(8'h21);
    chk("R5 single write", {idle_active, sfr_rdata[0]}, 2'b01);
    step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
    chk("R5 retire clears arm", sfr_rdata, 8'h00);
    wpcon(8'h20);
    chk("R5 unarmed IDLS", idle_active, 0);
    wpcon(8'h01);
    step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
    wpcon(8'h20);
    chk("R5 broken pair", idle_active, 0);

    wpcon(8'h01);
    chk("R4 armed, not idle", idle_active, 0);
    wpcon(8'h20);
    chk("R4 idle entered", idle_active, 1);
    chk("R6 rdata idle bits", {sfr_rdata[5], sfr_rdata[0]}, 2'b11);
    chk("R6 holds", {addr_latch_hold, prog_strobe_hold, port_freeze}, 3'b111);
    measure(24, per, mc, cpu, wdt);
    chk("R6 per runs", per, 24);
    chk("R6 mc runs", mc, 2);
    chk("R6 cpu/wdt stopped", cpu + wdt, 0);
    step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1);
    chk("R7 wake", idle_active, 0);
    chk("R7 bits cleared", sfr_rdata, 8'h00);
    chk("R7 cpu back", cpu_clk_en, 1);

    wpcon(8'h01); wpcon(8'h20);
    chk("R8 idle before reset", idle_active, 1);
    do_reset();
    chk("R8 idle after reset", idle_active, 0);
    chk("R8 rdata", sfr_rdata, 8'h00);
    chk("R8 enables", {cpu_clk_en, wdt_clk_en}, 2'b11);

    sw_save_en = 1'b0;
    wpcon(8'h11); wpcon(8'h20);
    chk("R9 locked", {idle_active, sfr_rdata}, 9'h000);
    wpcon(8'hFF);
    chk("R9 other bits kept", sfr_rdata, 8'hCE);
    sw_save_en = 1'b1;
    step(1'b1, 8'h86, 8'hFF, 1'b1, 1'b0);
    chk("R10 other addr", sfr_rdata, 8'hCE);
    wpcon(8'h4A);
    chk("R10 stored bits", sfr_rdata, 8'h4A);

    do_reset();
    m_sd = 0; m_arm = 0; m_idle = 0; m_keep = 0;
    for (int n = 0; n < 400; n++) begin
      logic we, ret, irq, en;
      logic [7:0] a, d;
      we = 0; ret = 0; irq = 0; a = 8'h87; d = 8'h00;
      en = ($urandom_range(0, 9) != 0);
      if (m_idle) irq = ($urandom_range(0, 2) == 0);
      else begin
        we = ($urandom_range(0, 2) != 0);
        ret = we | ($urandom_range(0, 1) == 1);
        if ($urandom_range(0, 7) == 0) a = 8'($urandom_range(0, 255));
        d = 8'($urandom_range(0, 255));
        if ($urandom_range(0, 1) == 1) d = d | 8'h01;
        if ($urandom_range(0, 1) == 1) d = d | 8'h20;
      end
      sw_save_en = en;
      model_step(we, a, d, ret, irq, en);
      step(we, a, d, ret, irq);
      chk("R4 R5 R9 R10 random rdata", sfr_rdata, read_model());
      chk("R4 R7 random idle", idle_active, m_idle);
      if (m_idle) chk("R6 random cpu", cpu_clk_en, 0);
    end
    sw_save_en = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule